// File: doc/BRIEF.md
# Clock Lane High-Speed Entry and Exit Controller

This block sequences the lane that carries the forwarded high-speed clock of a serial link. On a start request it walks the lane out of the low-power stop state and through a low-power request and a bridge state. It then drives a differential zero, and finally a free-running toggling clock. The data lane sequencers receive a grant only after the clock has toggled for a programmable number of bit periods. The clock keeps running after a stop request until every data lane reports idle. It then runs for a programmable post interval, drives a differential zero for the trail interval, and goes back to the stop state.

Every interval is a programmable count. The pre interval is given in bit periods and scaled by a cycles-per-bit register. All other intervals are given directly in controller cycles. A configuration checker compares the register values with the legal timing bounds, which it derives from the controller clock period parameter. It raises an error flag when a value is out of range, and while the flag is high a start request is not accepted.

Top module: `clk_lane_ctrl`

## Requirements
- R1: After reset, lane_st_o is 0 (LP-11), state_o is 0 (stop), grant_o is 0 and err_o is 0 for a legal configuration.
- R2: A start_i sampled in the stop state, with err_o low, moves the lane to LP-01 (lane_st_o=1, state_o=1) for lpx_cyc_i cycles and then to LP-00 (lane_st_o=2, state_o=2) for prep_cyc_i cycles. An interval value of 0 counts as 1 cycle.
- R3: After LP-00, the lane drives HS-0 (lane_st_o=3, state_o=3) for zero_cyc_i cycles and then toggles (lane_st_o=4).
- R4: The lane toggles for pre_ui_i*ui_cyc_i cycles with grant_o low (state_o=4). grant_o then rises (state_o=5). grant_o is high only in state 5, and only while the lane toggles.
- R5: A stop request taken while data_idle_i is high ends state 5 at that edge. The lane then toggles for post_cyc_i cycles with grant_o low (state_o=6).
- R6: After the post interval, the lane drives HS-0 (state_o=7) for trail_cyc_i cycles and then returns to LP-11 (state 0).
- R7: A stop_i pulse while data_idle_i is low is held. The lane stays in state 5 with grant_o high until data_idle_i rises, and then enters state 6 without a second stop_i.
- R8: err_o rises one cycle after prep_cyc_i falls outside [ceil(38000/CLK_PS), floor(95000/CLK_PS)].
- R9: err_o also rises when ui_cyc_i is 0, when pre_ui_i < 8, when trail_cyc_i < ceil(60000/CLK_PS), or when post_cyc_i < ceil(60000/CLK_PS) + 52*ui_cyc_i.
- R10: While err_o is high, start_i is ignored and state_o stays 0.
- R11: The state-to-lane mapping is 0→LP-11(0), 1→LP-01(1), 2→LP-00(2), 3→HS-0(3), 4/5/6→toggling(4) and 7→HS-0(3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to enter high-speed clocking |
| stop_i | input | 1 | Request to leave high-speed clocking |
| data_idle_i | input | 1 | All data lanes have finished their trail and are idle |
| lpx_cyc_i | input | CW | Low-power request length, cycles |
| prep_cyc_i | input | CW | Bridge (LP-00) length, cycles |
| zero_cyc_i | input | CW | HS-0 length before toggling, cycles |
| pre_ui_i | input | UW | Pre interval, bit periods |
| ui_cyc_i | input | UW | Controller cycles per bit period |
| post_cyc_i | input | CW | Post interval, cycles |
| trail_cyc_i | input | CW | Trail HS-0 length, cycles |
| grant_o | output | 1 | Data lanes may begin their entry |
| lane_st_o | output | 3 | Encoded lane line state |
| state_o | output | 3 | Controller state encoding |
| err_o | output | 1 | Configuration out of range |

## Verification
The bench builds the block with CLK_PS=8000, CW=16 and UW=8. The legal bridge window is then 5 to 11 cycles, the trail floor is 8 cycles and the post floor is 8+52*ui_cyc_i cycles. These windows are short enough that the bench can run whole bursts at both edges of each range and test the values just outside them. Bursts use one and two cycles per bit period and zero-valued intervals. The stop tests cover a stop honoured at once, and a stop held while the data lanes are busy and released later by the idle input alone.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;
  typedef enum logic [2:0] {
    LN_LP11 = 3'd0, LN_LP01 = 3'd1, LN_LP00 = 3'd2, LN_HS0 = 3'd3, LN_HSCLK = 3'd4
  } lane_e;

  typedef enum logic [2:0] {
    ST_STOP = 3'd0, ST_LPRQ = 3'd1, ST_PREP = 3'd2, ST_ZERO = 3'd3,
    ST_PRE = 3'd4, ST_RUN = 3'd5, ST_POST = 3'd6, ST_TRAIL = 3'd7
  } fsm_e;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // expired timer stays expired until reloaded
  assert_timer_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/clk_lane_cfg_chk.sv
module clk_lane_cfg_chk
  import clk_lane_pkg::*;
#(
  parameter int unsigned CW     = 16,
  parameter int unsigned UW     = 8,
  parameter int unsigned CLK_PS = 8000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] prep_cyc_i,
  input  logic [UW-1:0] pre_ui_i,
  input  logic [UW-1:0] ui_cyc_i,
  input  logic [CW-1:0] post_cyc_i,
  input  logic [CW-1:0] trail_cyc_i,
  output logic          err_o
);
  localparam int unsigned PW = CW + UW + 7;
  localparam logic [CW-1:0] PREP_MIN  = CW'(ceil_div(38000, CLK_PS));
  localparam logic [CW-1:0] PREP_MAX  = CW'(95000 / CLK_PS);
  localparam logic [CW-1:0] TRAIL_MIN = CW'(ceil_div(60000, CLK_PS));
  localparam logic [UW-1:0] PRE_MIN   = UW'(8);

  logic [PW-1:0] post_min;
  logic          bad, err_q;

  always_comb begin
    post_min = PW'(TRAIL_MIN) + PW'(ui_cyc_i) * PW'(52);
    bad = (prep_cyc_i < PREP_MIN) || (prep_cyc_i > PREP_MAX)
       || (ui_cyc_i == '0) || (pre_ui_i < PRE_MIN)
       || (trail_cyc_i < TRAIL_MIN) || (PW'(post_cyc_i) < post_min);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= bad;
  end

  assign err_o = err_q;
endmodule

// File: rtl/clk_lane_ctrl.sv
module clk_lane_ctrl
  import clk_lane_pkg::*;
#(
  parameter int unsigned CW     = 16,
  parameter int unsigned UW     = 8,
  parameter int unsigned CLK_PS = 8000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          data_idle_i,
  input  logic [CW-1:0] lpx_cyc_i,
  input  logic [CW-1:0] prep_cyc_i,
  input  logic [CW-1:0] zero_cyc_i,
  input  logic [UW-1:0] pre_ui_i,
  input  logic [UW-1:0] ui_cyc_i,
  input  logic [CW-1:0] post_cyc_i,
  input  logic [CW-1:0] trail_cyc_i,
  output logic          grant_o,
  output logic [2:0]    lane_st_o,
  output logic [2:0]    state_o,
  output logic          err_o
);
  fsm_e          state_q, nxt;
  lane_e         lane;
  logic          stop_req_q, go_post, load, done, err;
  logic [CW-1:0] ld_val, pre_cyc;

  function automatic logic [CW-1:0] m1(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  clk_lane_cfg_chk #(.CW(CW), .UW(UW), .CLK_PS(CLK_PS)) u_chk (
    .clk_i, .rst_ni, .prep_cyc_i, .pre_ui_i, .ui_cyc_i,
    .post_cyc_i, .trail_cyc_i, .err_o(err)
  );

  clk_lane_timer #(.CW(CW)) u_tmr (
    .clk_i, .rst_ni, .load_i(load), .val_i(ld_val), .done_o(done)
  );

  assign pre_cyc = CW'(pre_ui_i) * CW'(ui_cyc_i);
  assign go_post = (stop_req_q || stop_i) && data_idle_i;

  always_comb begin
    nxt    = state_q;
    load   = 1'b0;
    ld_val = '0;
    unique case (state_q)
      ST_STOP:  if (start_i && !err) begin nxt = ST_LPRQ;  load = 1'b1; ld_val = m1(lpx_cyc_i);   end
      ST_LPRQ:  if (done)            begin nxt = ST_PREP;  load = 1'b1; ld_val = m1(prep_cyc_i);  end
      ST_PREP:  if (done)            begin nxt = ST_ZERO;  load = 1'b1; ld_val = m1(zero_cyc_i);  end
      ST_ZERO:  if (done)            begin nxt = ST_PRE;   load = 1'b1; ld_val = m1(pre_cyc);     end
      ST_PRE:   if (done)                  nxt = ST_RUN;
      ST_RUN:   if (go_post)         begin nxt = ST_POST;  load = 1'b1; ld_val = m1(post_cyc_i);  end
      ST_POST:  if (done)            begin nxt = ST_TRAIL; load = 1'b1; ld_val = m1(trail_cyc_i); end
      ST_TRAIL: if (done)                  nxt = ST_STOP;
      default:                             nxt = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_STOP;
      stop_req_q <= 1'b0;
    end else begin
      state_q    <= nxt;
      // stop held until data lanes go idle
      stop_req_q <= (state_q == ST_RUN) && (stop_req_q || stop_i) && !go_post;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_STOP:                 lane = LN_LP11;
      ST_LPRQ:                 lane = LN_LP01;
      ST_PREP:                 lane = LN_LP00;
      ST_ZERO, ST_TRAIL:       lane = LN_HS0;
      default:                 lane = LN_HSCLK;
    endcase
  end

  assign grant_o   = (state_q == ST_RUN);
  assign lane_st_o = lane;
  assign state_o   = state_q;
  assign err_o     = err;

  assert_grant_clocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (lane_st_o == LN_HSCLK));
  assert_grant_after_pre_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> ($past(state_q) == ST_PRE));
  assert_bridge_from_lp01_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_st_o == LN_LP00 && $past(lane_st_o) != LN_LP00) |-> ($past(lane_st_o) == LN_LP01));
  assert_stop_waits_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !data_idle_i) |=> (state_q == ST_RUN));
  assert_err_blocks_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && err_o) |=> (state_q == ST_STOP));
  assert_trail_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_TRAIL && state_q != ST_TRAIL) |-> (lane_st_o == LN_LP11));
endmodule

// File: tb/tb_clk_lane_ctrl.sv
module tb_clk_lane_ctrl;
  localparam int CW = 16, UW = 8, CLK_PS = 8000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start, stop, idle;
  logic [CW-1:0] lpx, prep, zero, post, trail;
  logic [UW-1:0] pre_ui, ui;
  logic grant, err;
  logic [2:0] lane_st, st;

  int checks = 0, errors = 0;
  int exp_st[$], exp_len[$];
  int cur = 0, len = 0;

  always #4 clk = ~clk;

  clk_lane_ctrl #(.CW(CW), .UW(UW), .CLK_PS(CLK_PS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .data_idle_i(idle),
    .lpx_cyc_i(lpx), .prep_cyc_i(prep), .zero_cyc_i(zero), .pre_ui_i(pre_ui),
    .ui_cyc_i(ui), .post_cyc_i(post), .trail_cyc_i(trail),
    .grant_o(grant), .lane_st_o(lane_st), .state_o(st), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lane_for(input int s);
    case (s)
      0: return 0; 1: return 1; 2: return 2; 3: return 3; 7: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic string req_for(input int s);
    case (s)
      1, 2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R5"; default: return "R6";
    endcase
  endfunction

  // monitor: segments of state_o compared against the scoreboard queue
  always @(negedge clk) if (rst_n) begin
    if (int'(st) != cur) begin
      if (cur != 0) begin
        if (exp_st.size() == 0) chk(0, "R11 unexpected segment", cur, -1);
        else begin
          int es, el;
          es = exp_st.pop_front();
          el = exp_len.pop_front();
          chk(cur == es, req_for(es), cur, es);
          if (el != 0) chk(len == el, req_for(es), len, el);
        end
      end
      chk(int'(lane_st) == lane_for(int'(st)), "R11 lane map", int'(lane_st), lane_for(int'(st)));
      chk(grant == (st == 3'd5), "R4 grant", int'(grant), int'(st == 3'd5));
      cur = int'(st);
      len = 1;
    end else len++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic set_cfg(input int l, p, z, pu, u, po, t);
    lpx = CW'(l); prep = CW'(p); zero = CW'(z); pre_ui = UW'(pu);
    ui = UW'(u); post = CW'(po); trail = CW'(t);
  endtask

  // driver: one burst; held=1 issues stop while lanes busy
  task automatic burst(input int l, p, z, pu, u, po, t, input bit held);
    set_cfg(l, p, z, pu, u, po, t);
    idle = 1'b0;
    cyc(2);
    chk(err == 1'b0, "R8 legal cfg", int'(err), 0);
    exp_st.push_back(1); exp_len.push_back(one(l));
    exp_st.push_back(2); exp_len.push_back(one(p));
    exp_st.push_back(3); exp_len.push_back(one(z));
    exp_st.push_back(4); exp_len.push_back(one(pu * u));
    exp_st.push_back(5); exp_len.push_back(0);
    exp_st.push_back(6); exp_len.push_back(one(po));
    exp_st.push_back(7); exp_len.push_back(one(t));
    start = 1'b1; cyc(1); start = 1'b0;
    while (st != 3'd5) cyc(1);
    if (held) begin
      stop = 1'b1; cyc(1); stop = 1'b0;
      cyc(5);
      chk(st == 3'd5 && grant, "R7 stop waits", int'(st), 5);
      idle = 1'b1; cyc(1);
      chk(st == 3'd6 && !grant, "R7 latched stop", int'(st), 6);
    end else begin
      stop = 1'b1; idle = 1'b1; cyc(1); stop = 1'b0;
      chk(st == 3'd6, "R5 immediate stop", int'(st), 6);
    end
    while (st != 3'd0) cyc(1);
    cyc(3);
  endtask

  task automatic err_case(input int p, pu, u, po, t, input string req, input bit exp);
    set_cfg(2, p, 2, pu, u, po, t);
    cyc(2);
    chk(err == exp, req, int'(err), int'(exp));
  endtask

  initial begin
    cyc(20000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    start = 0; stop = 0; idle = 0;
    set_cfg(2, 5, 3, 8, 1, 60, 8);
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(lane_st == 3'd0 && st == 3'd0 && !grant && !err, "R1 reset", int'(lane_st), 0);

    burst(2, 5, 3, 8, 1, 60, 8, 1'b0);      // lower bridge bound, post at floor
    burst(1, 11, 1, 9, 2, 120, 10, 1'b1);   // upper bridge bound, held stop
    burst(0, 6, 0, 8, 2, 112, 8, 1'b0);     // zero-valued intervals count as 1

    err_case(4, 8, 1, 60, 8, "R8 prep below", 1'b1);
    err_case(12, 8, 1, 60, 8, "R8 prep above", 1'b1);
    err_case(11, 8, 1, 60, 8, "R8 prep top ok", 1'b0);
    err_case(5, 7, 1, 60, 8, "R9 pre short", 1'b1);
    err_case(5, 8, 0, 60, 8, "R9 ui zero", 1'b1);
    err_case(5, 8, 2, 111, 8, "R9 post short", 1'b1);
    err_case(5, 8, 1, 60, 7, "R9 trail short", 1'b1);

    start = 1'b1; cyc(1); start = 1'b0;
    cyc(3);
    chk(st == 3'd0 && lane_st == 3'd0, "R10 start ignored", int'(st), 0);

    chk(exp_st.size() == 0, "R11 all segments seen", exp_st.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule